// File: doc/BRIEF.md
# OTP Fuse Access Bridge

This block connects a simple host register port to a one-time-programmable fuse array of 37 words of 32 bits each. Software first places a value in a data register. It then writes a command register. That command word holds the fuse word address together with two trigger bits: one for a read and one for a program. The bridge runs the fuse transaction for a fixed number of cycles and reports the outcome in status registers. An acknowledge flag shows that a read has finished, or that a program command has been taken. A separate programming-complete flag shows that a program has finished. Read results are placed in a read-data register.

The fuse array itself sits outside the bridge. The bridge drives a word address, a read enable and a program enable. During a program it also drives a burn mask, and each 1 in the mask burns the matching fuse bit. Both latencies are parameters given in clock cycles. The read latency is meant to be shorter than the program latency. Commands that arrive while an operation is running are dropped. Malformed commands are refused and set an error bit.

Top module: `otp_fuse_bridge`

## Requirements
- R1: Host registers are decoded on `host_addr`:
  - 0 is the data register (read/write).
  - 1 is the command register (read returns the last command word).
  - 2 is the read-data register.
  - 3 is the acknowledge register (bit 0).
  - 4 is the programming-complete register (bit 0).
  - 5 is status (bit 0 busy, bit 1 error).
  - All of these read 0 after reset.
- R2: A command word with bit 16 set, bit 17 clear and an address in bits 15:0 below 37 starts a read. `fuse_rd_en` is high for RD_LAT cycles. Exactly RD_LAT clock edges after the launching edge, the acknowledge bit is 1 and the read-data register holds that fuse word.
- R3: A command word with bit 17 set, bit 16 clear and a valid address starts a program. `fuse_prog_en` is high for PROG_LAT cycles. The acknowledge bit is 1 one edge after launch. The programming-complete bit is 1 PROG_LAT edges after launch.
- R4: A program only burns bits. `fuse_mask` is the data register, and a fuse bit that is 0 in the mask keeps its old value. A later read therefore returns the old word ORed with the mask.
- R5: Status bit 0 reads 1 while an operation runs. A command write during that time is ignored: it neither starts nor alters any operation.
- R6: Launching an operation clears the acknowledge and programming-complete bits at the launching edge.
- R7: A command word with both bit 16 and bit 17 set is rejected. No fuse access runs, status bit 1 becomes 1, and the acknowledge and programming-complete bits keep their values.
- R8: A read or program command whose address field (bits 15:0) is 37 or more is rejected in the same way as R7. Address 36 is accepted.
- R9: A command word with neither trigger bit set starts nothing and leaves the error bit unchanged. The next accepted launch clears the error bit.
- R10: The burn mask is captured at launch. Writing the data register during a program does not change the bits being burned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational on host_addr) |
| fuse_addr | output | 6 | Fuse word address |
| fuse_rd_en | output | 1 | Fuse read enable |
| fuse_prog_en | output | 1 | Fuse program enable |
| fuse_mask | output | 32 | Bits to burn during a program |
| fuse_rdata | input | 32 | Fuse word read back |

## Verification
The bench counts the clock edges from each launch to the acknowledge flag and to the programming-complete flag. A sequencer with an off-by-one counter, or one that reports programming complete together with the acknowledge, therefore gives the wrong count. Three commands are sent in the middle of a program to test busy handling: a read command, a new data value and a second program. A design that let any of these through would overwrite the read-data register, burn the wrong mask or clear the flags early. Both-bit commands and the address boundary at 36/37 are checked against the fuse enables and the error bit. A decoder that gave one trigger priority, or used `<=` instead of `<`, would start an access there. Re-burning a word that already holds preloaded bits shows whether the design clears bits instead of only setting them.

// File: rtl/otp_bridge_pkg.sv
// Package: shared register offsets and types for the OTP fuse access bridge.
// Assumes: the host register index is at least 3 bits wide.
package otp_bridge_pkg;

    localparam int OFS_DATA  = 0;
    localparam int OFS_CMD   = 1;
    localparam int OFS_RDATA = 2;
    localparam int OFS_ACK   = 3;
    localparam int OFS_DONE  = 4;
    localparam int OFS_STAT  = 5;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_READ = 2'd1,
        SEQ_PROG = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic launch_rd;
        logic launch_wr;
        logic reject;
    } cmd_verdict_t;

endpackage

// File: rtl/otp_host_regs.sv
// Module: host-side register file of the fuse bridge.
// Holds the data and last-command registers and muxes all readable state
// onto host_rdata. Reads are combinational on host_addr.
// Assumes: one host write per cycle; host_addr indexes 32-bit registers.
module otp_host_regs
    import otp_bridge_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int HOST_AW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic [DATA_W-1:0]  rd_word,
    input  logic               ack,
    input  logic               prog_done,
    input  logic               busy,
    input  logic               err,
    output logic [DATA_W-1:0]  data_reg,
    output logic               cmd_wr,
    output logic [DATA_W-1:0]  cmd_word
);

    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] cmd_q;
    logic              wr_data;

    assign wr_data  = host_wr_en && (host_addr == HOST_AW'(OFS_DATA));
    assign cmd_wr   = host_wr_en && (host_addr == HOST_AW'(OFS_CMD));
    assign cmd_word = host_wdata;
    assign data_reg = data_q;

    // Capture the data register and the last command word written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cmd_q  <= '0;
        end else begin
            if (wr_data) data_q <= host_wdata;
            if (cmd_wr)  cmd_q  <= host_wdata;
        end
    end

    // Select the register addressed by the host for read-back.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            HOST_AW'(OFS_DATA):  host_rdata = data_q;
            HOST_AW'(OFS_CMD):   host_rdata = cmd_q;
            HOST_AW'(OFS_RDATA): host_rdata = rd_word;
            HOST_AW'(OFS_ACK):   host_rdata = DATA_W'(ack);
            HOST_AW'(OFS_DONE):  host_rdata = DATA_W'(prog_done);
            HOST_AW'(OFS_STAT):  host_rdata = DATA_W'({err, busy});
            default:             host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/otp_cmd_check.sv
// Module: command word decoder and validity check.
// Splits a command word into trigger bits and address, refuses both-trigger
// and out-of-range commands, and keeps the sticky error bit.
// Assumes: busy comes from the sequencer in the same cycle.
module otp_cmd_check
    import otp_bridge_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FUSE_WORDS = 37,
    parameter int FUSE_AW    = 6,
    parameter int RD_BIT     = 16,
    parameter int WR_BIT     = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [DATA_W-1:0]  cmd_word,
    input  logic               busy,
    output cmd_verdict_t       verdict,
    output logic [FUSE_AW-1:0] op_addr,
    output logic               err
);

    localparam int FIELD_W = RD_BIT;

    logic [FIELD_W-1:0] addr_field;
    logic               want_rd;
    logic               want_wr;
    logic               in_range;
    logic               err_q;

    assign addr_field = cmd_word[FIELD_W-1:0];
    assign want_rd    = cmd_word[RD_BIT];
    assign want_wr    = cmd_word[WR_BIT];
    assign in_range   = (DATA_W'(addr_field) < DATA_W'(FUSE_WORDS));
    assign op_addr    = addr_field[FUSE_AW-1:0];
    assign err        = err_q;

    // Classify an idle-time command write as read, program or reject.
    always_comb begin
        verdict = '0;
        if (cmd_wr && !busy) begin
            if (want_rd && want_wr)
                verdict.reject = 1'b1;
            else if ((want_rd || want_wr) && !in_range)
                verdict.reject = 1'b1;
            else begin
                verdict.launch_rd = want_rd;
                verdict.launch_wr = want_wr;
            end
        end
    end

    // Set the error bit on a reject, clear it on an accepted launch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (verdict.reject)
            err_q <= 1'b1;
        else if (verdict.launch_rd || verdict.launch_wr)
            err_q <= 1'b0;
    end

    // R7
    // both_bits_reject_chk
    both_bits_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_word[RD_BIT] && cmd_word[WR_BIT]) |=> err_q);

    // R8
    // addr_range_chk
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict.launch_rd || verdict.launch_wr) |-> (int'(op_addr) < FUSE_WORDS));

    // R9
    // idle_word_no_err_chk
    idle_word_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_word[RD_BIT] && !cmd_word[WR_BIT]) |=> $stable(err_q));

endmodule

// File: rtl/otp_fuse_seq.sv
// Module: fuse transaction sequencer.
// Runs one read or program at a time with a shared down-counter, drives the
// fuse enables, and owns the acknowledge, programming-complete and
// read-data state.
// Assumes: launch requests arrive only while idle; RD_LAT, PROG_LAT >= 1.
module otp_fuse_seq
    import otp_bridge_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int FUSE_AW  = 6,
    parameter int RD_LAT   = 4,
    parameter int PROG_LAT = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_verdict_t       verdict,
    input  logic [FUSE_AW-1:0] op_addr,
    input  logic [DATA_W-1:0]  data_reg,
    input  logic [DATA_W-1:0]  fuse_rdata,
    output logic [FUSE_AW-1:0] fuse_addr,
    output logic               fuse_rd_en,
    output logic               fuse_prog_en,
    output logic [DATA_W-1:0]  fuse_mask,
    output logic               busy,
    output logic               ack,
    output logic               prog_done,
    output logic [DATA_W-1:0]  rd_word
);

    localparam int MAX_LAT = (PROG_LAT > RD_LAT) ? PROG_LAT : RD_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    seq_state_e         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FUSE_AW-1:0] addr_q;
    logic [DATA_W-1:0]  mask_q;
    logic [DATA_W-1:0]  rd_q;
    logic               ack_q;
    logic               done_q;
    logic               launch;

    assign launch       = verdict.launch_rd || verdict.launch_wr;
    assign busy         = (state_q != SEQ_IDLE);
    assign fuse_rd_en   = (state_q == SEQ_READ);
    assign fuse_prog_en = (state_q == SEQ_PROG);
    assign fuse_addr    = addr_q;
    assign fuse_mask    = fuse_prog_en ? mask_q : '0;
    assign ack          = ack_q;
    assign prog_done    = done_q;
    assign rd_word      = rd_q;

    // Step the transaction: launch, count down the latency, report completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            mask_q  <= '0;
            rd_q    <= '0;
            ack_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (verdict.launch_rd) begin
                        state_q <= SEQ_READ;
                        cnt_q   <= CNT_W'(RD_LAT - 1);
                        addr_q  <= op_addr;
                        ack_q   <= 1'b0;
                        done_q  <= 1'b0;
                    end else if (verdict.launch_wr) begin
                        state_q <= SEQ_PROG;
                        cnt_q   <= CNT_W'(PROG_LAT - 1);
                        addr_q  <= op_addr;
                        mask_q  <= data_reg;
                        ack_q   <= 1'b0;
                        done_q  <= 1'b0;
                    end
                end
                SEQ_READ: begin
                    if (cnt_q == '0) begin
                        rd_q    <= fuse_rdata;
                        ack_q   <= 1'b1;
                        state_q <= SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SEQ_PROG: begin
                    ack_q <= 1'b1;
                    if (cnt_q == '0) begin
                        done_q  <= 1'b1;
                        state_q <= SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R5
    // no_launch_busy_chk
    no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch);

    // R6
    // launch_clears_flags_chk
    launch_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (!ack_q && !done_q));

    // R3
    // done_after_ack_chk
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ack_q);

    // R3
    // done_from_prog_chk
    done_from_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(fuse_prog_en));

    // R2
    // read_ack_source_chk
    read_ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_q) && !fuse_prog_en) |-> $past(fuse_rd_en));

    // R10
    // mask_hold_chk
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_prog_en && $past(fuse_prog_en)) |-> ($stable(fuse_mask) && $stable(fuse_addr)));

endmodule

// File: rtl/otp_fuse_bridge.sv
// Module: top of the OTP fuse access bridge.
// Connects the host register file, the command checker and the fuse
// sequencer. The fuse array is external; it burns the mask bits while
// fuse_prog_en is high and presents the addressed word on fuse_rdata.
// Assumes: synchronous active-low reset; fuse_rdata valid while fuse_rd_en.
module otp_fuse_bridge
    import otp_bridge_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int HOST_AW    = 3,
    parameter int FUSE_WORDS = 37,
    parameter int FUSE_AW    = $clog2(FUSE_WORDS),
    parameter int RD_BIT     = 16,
    parameter int WR_BIT     = 17,
    parameter int RD_LAT     = 4,
    parameter int PROG_LAT   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic [FUSE_AW-1:0] fuse_addr,
    output logic               fuse_rd_en,
    output logic               fuse_prog_en,
    output logic [DATA_W-1:0]  fuse_mask,
    input  logic [DATA_W-1:0]  fuse_rdata
);

    logic [DATA_W-1:0]  data_reg;
    logic               cmd_wr;
    logic [DATA_W-1:0]  cmd_word;
    logic [DATA_W-1:0]  rd_word;
    logic               ack;
    logic               prog_done;
    logic               busy;
    logic               err;
    cmd_verdict_t       verdict;
    logic [FUSE_AW-1:0] op_addr;

    otp_host_regs #(
        .DATA_W  (DATA_W),
        .HOST_AW (HOST_AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rd_word    (rd_word),
        .ack        (ack),
        .prog_done  (prog_done),
        .busy       (busy),
        .err        (err),
        .data_reg   (data_reg),
        .cmd_wr     (cmd_wr),
        .cmd_word   (cmd_word)
    );

    otp_cmd_check #(
        .DATA_W     (DATA_W),
        .FUSE_WORDS (FUSE_WORDS),
        .FUSE_AW    (FUSE_AW),
        .RD_BIT     (RD_BIT),
        .WR_BIT     (WR_BIT)
    ) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_word (cmd_word),
        .busy     (busy),
        .verdict  (verdict),
        .op_addr  (op_addr),
        .err      (err)
    );

    otp_fuse_seq #(
        .DATA_W   (DATA_W),
        .FUSE_AW  (FUSE_AW),
        .RD_LAT   (RD_LAT),
        .PROG_LAT (PROG_LAT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .verdict      (verdict),
        .op_addr      (op_addr),
        .data_reg     (data_reg),
        .fuse_rdata   (fuse_rdata),
        .fuse_addr    (fuse_addr),
        .fuse_rd_en   (fuse_rd_en),
        .fuse_prog_en (fuse_prog_en),
        .fuse_mask    (fuse_mask),
        .busy         (busy),
        .ack          (ack),
        .prog_done    (prog_done),
        .rd_word      (rd_word)
    );

    // R2
    // enables_exclusive_chk
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_rd_en && fuse_prog_en));

    // R7
    // reject_no_access_chk
    reject_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict.reject |=> (!fuse_rd_en && !fuse_prog_en));

endmodule

// File: tb/otp_fuse_bridge_tb_top.sv
// Directed bench for the OTP fuse access bridge with a behavioural fuse array.
module otp_fuse_bridge_tb_top;

    localparam int RD_LAT   = 4;
    localparam int PROG_LAT = 24;
    localparam int WORDS    = 37;

    localparam logic [2:0] A_DATA = 3'd0, A_CMD = 3'd1, A_RDATA = 3'd2,
                           A_ACK = 3'd3, A_DONE = 3'd4, A_STAT = 3'd5;
    localparam logic [31:0] RD_TRIG = 32'h0001_0000;
    localparam logic [31:0] WR_TRIG = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [5:0]  fuse_addr;
    logic        fuse_rd_en;
    logic        fuse_prog_en;
    logic [31:0] fuse_mask;
    logic [31:0] fuse_rdata;

    logic [31:0] fuse_mem [WORDS];
    logic [31:0] exp_mem  [WORDS];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    otp_fuse_bridge dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .fuse_addr    (fuse_addr),
        .fuse_rd_en   (fuse_rd_en),
        .fuse_prog_en (fuse_prog_en),
        .fuse_mask    (fuse_mask),
        .fuse_rdata   (fuse_rdata)
    );

    // Behavioural fuse array: burns set bits only.
    function automatic logic [31:0] preload(int i);
        return (32'(i) * 32'h0103_0507) & 32'h0F0F_0F0F;
    endfunction

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            fuse_mem[i] = preload(i);
            exp_mem[i]  = preload(i);
        end
    end

    always @(posedge clk)
        if (fuse_prog_en && int'(fuse_addr) < WORDS)
            fuse_mem[fuse_addr] <= fuse_mem[fuse_addr] | fuse_mask;

    assign fuse_rdata = (fuse_rd_en && int'(fuse_addr) < WORDS) ? fuse_mem[fuse_addr] : 32'h0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] ofs, input logic [31:0] val);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = ofs; host_wdata = val;
        @(posedge clk); #1;
        host_wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_read(input logic [2:0] ofs, output logic [31:0] val);
        host_addr = ofs; #1; val = host_rdata;
    endtask

    task automatic wait_bit(input logic [2:0] ofs, output int n);
        logic [31:0] v;
        n = 0;
        host_read(ofs, v);
        while (!v[0] && n < 1000) begin
            @(negedge clk); n++;
            host_read(ofs, v);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            host_read(3'(a), v);
            chk(v == 32'h0, "R1", $sformatf("reg %0d after reset", a), v, 32'h0);
        end
    endtask

    task automatic t_read(input int addr);
        logic [31:0] v; int n;
        host_write(A_CMD, RD_TRIG | 32'(addr));
        host_read(A_ACK, v);
        chk(v[0] == 1'b0, "R6", "ack cleared at read launch", v, 0);
        host_read(A_STAT, v);
        chk(v[0] == 1'b1, "R5", "busy during read", v, 1);
        wait_bit(A_ACK, n);
        chk(n == RD_LAT, "R2", "read ack latency", n, RD_LAT);
        host_read(A_RDATA, v);
        chk(v == exp_mem[addr], "R2", $sformatf("read word %0d", addr), v, exp_mem[addr]);
    endtask

    task automatic t_prog(input int addr, input logic [31:0] mask);
        logic [31:0] v; int n1, n2;
        host_write(A_DATA, mask);
        host_write(A_CMD, WR_TRIG | 32'(addr));
        host_read(A_DONE, v);
        chk(v[0] == 1'b0, "R6", "done cleared at program launch", v, 0);
        chk(fuse_prog_en && fuse_mask == mask, "R3", "program enable and mask", fuse_mask, mask);
        wait_bit(A_ACK, n1);
        chk(n1 == 1, "R3", "program ack latency", n1, 1);
        wait_bit(A_DONE, n2);
        chk(n1 + n2 == PROG_LAT, "R3", "program done latency", n1 + n2, PROG_LAT);
        exp_mem[addr] = exp_mem[addr] | mask;
    endtask

    task automatic t_or_only;
        t_prog(5, 32'hF000_000F);
        t_read(5);
        chk(exp_mem[5] == (preload(5) | 32'hF000_000F), "R4", "word keeps old bits", exp_mem[5],
            preload(5) | 32'hF000_000F);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v, old_rd; int n;
        host_read(A_RDATA, old_rd);
        host_write(A_DATA, 32'h0000_1100);
        host_write(A_CMD, WR_TRIG | 32'd9);
        host_write(A_CMD, RD_TRIG | 32'd2);
        host_write(A_DATA, 32'hFFFF_FFFF);
        host_write(A_CMD, WR_TRIG | 32'd3);
        chk(fuse_mask == 32'h0000_1100 && fuse_addr == 6'd9, "R10", "mask held during program",
            fuse_mask, 32'h0000_1100);
        wait_bit(A_DONE, n);
        @(negedge clk);
        host_read(A_STAT, v);
        chk(v[0] == 1'b0, "R5", "idle after program", v, 0);
        host_read(A_RDATA, v);
        chk(v == old_rd, "R5", "read while busy ignored", v, old_rd);
        exp_mem[9] = exp_mem[9] | 32'h0000_1100;
        t_read(3);
        t_read(9);
    endtask

    task automatic t_reject(input logic [31:0] word, input string req);
        logic [31:0] v, ack0;
        host_read(A_ACK, ack0);
        host_write(A_CMD, word);
        host_read(A_STAT, v);
        chk(v[1:0] == 2'b10, req, "reject sets error, not busy", v, 2);
        chk(!fuse_rd_en && !fuse_prog_en, req, "no fuse access", {fuse_rd_en, fuse_prog_en}, 0);
        host_read(A_ACK, v);
        chk(v == ack0, req, "ack unchanged", v, ack0);
    endtask

    task automatic t_idle_word;
        logic [31:0] v;
        host_write(A_CMD, 32'd3);
        host_read(A_STAT, v);
        chk(v[1:0] == 2'b10, "R9", "no-trigger word: no op, error kept", v, 2);
        host_read(A_CMD, v);
        chk(v == 32'd3, "R1", "command readback", v, 3);
        t_read(36);
        host_read(A_STAT, v);
        chk(v[1] == 1'b0, "R9", "accepted launch clears error", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read(0);
        t_read(12);
        t_prog(20, 32'h8000_0001);
        t_read(20);
        t_or_only();
        t_busy_ignore();
        t_reject(RD_TRIG | WR_TRIG | 32'd4, "R7");
        t_reject(RD_TRIG | 32'd37, "R8");
        t_reject(WR_TRIG | 32'h0000_FFFF, "R8");
        t_idle_word();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule